// File: doc/BRIEF.md
# Address Region Access Guard

This block sits beside a processor's bus and judges every access against a small table of programmable address windows. Software fills the table through a descriptor write port. Each entry holds a lower and an upper bound, counted in 8-byte granules, along with an enable bit and two restriction bits. One restriction bit forbids stores and the other forbids instruction fetches. Each access presents an address, a kind (load, store or fetch) and a privilege flag. The block returns an allow decision within the same cycle.

The table only limits unprivileged code. Privileged accesses always pass. An unprivileged access that lands in no enabled window, or that only lands in windows which forbid its kind, is a violation. A violation drives a single-cycle non-maskable request on the following cycle. The first violation also records its address and kind in a sticky status record, which software releases with a clear strobe.

Top module: `rgn_guard`

## Requirements
- R1: After reset every entry is disabled, `sts_valid` is 0 and `nmi_req` is 0. A pulse on `cfg_we` writes entry `cfg_sel` with its bounds and bits, and the new contents govern decisions from the next cycle onward.
- R2: Bounds are granule numbers, meaning address bits [23:3]. An entry covers every byte from `cfg_lo`*8 through `cfg_hi`*8+7 inclusive, and access address bits [2:0] play no part in the match.
- R3: Kind encoding is 0 = load, 1 = store and 2 = fetch. A load is allowed by any enabled entry that matches. A store is allowed only by a matching entry whose no-store bit is 0, and a fetch only by a matching entry whose no-fetch bit is 0.
- R4: When several enabled entries cover an address, the access is allowed if any one of them permits its kind.
- R5: An access with `acc_super` high is always allowed.
- R6: An unprivileged access that matches no enabled entry is denied, even when a disabled entry covers it. Kind code 3 is always denied in the unprivileged state. `acc_allow` is 1 whenever `acc_valid` is 0.
- R7: `nmi_req` is high for exactly one cycle, on the cycle after each denied valid access, and is low otherwise.
- R8: A denied access while `sts_valid` is 0 sets `sts_valid` and records its address and kind in `sts_addr` and `sts_kind` on the next cycle. Later violations leave the record unchanged while `sts_valid` stays set.
- R9: A pulse on `sts_clr` drops `sts_valid` on the next cycle. If a violation arrives in the same cycle as the clear, that violation is recorded and `sts_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_sel | input | 3 | Entry index to write |
| cfg_lo | input | 21 | Lower bound, granule number |
| cfg_hi | input | 21 | Upper bound, granule number (inclusive) |
| cfg_en | input | 1 | Entry enable |
| cfg_nw | input | 1 | No-store restriction |
| cfg_nx | input | 1 | No-fetch restriction |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 24 | Access byte address |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| acc_super | input | 1 | Privileged state flag |
| sts_clr | input | 1 | Release the sticky violation record |
| acc_allow | output | 1 | Combinational allow decision |
| nmi_req | output | 1 | Non-maskable violation request pulse |
| sts_valid | output | 1 | Violation record holds data |
| sts_addr | output | 24 | Address of the recorded violation |
| sts_kind | output | 2 | Kind of the recorded violation |

## Verification
The properties assume that `acc_valid`, `acc_kind`, `acc_super` and `sts_clr` are driven to known values on every clocked cycle after reset. They also assume that a descriptor write changes the table only one cycle later. The stimulus drives every input at the falling edge. It holds each access for one cycle, and between accesses it drops `acc_valid` and keeps the clear strobe low except when a test needs it. This keeps each access, each clear and each table write separate from the others, apart from the one deliberate case that pairs a clear with a violation in the same cycle.

// File: rtl/rgn_pkg.sv
package rgn_pkg;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_RSV   = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic en;
        logic nw;
        logic nx;
    } rgn_attr_t;

endpackage

// File: rtl/rgn_table.sv
module rgn_table
    import rgn_pkg::*;
#(
    parameter int NUM_RGN = 8,
    parameter int GW      = 21,
    parameter int IDX_W   = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_sel,
    input  logic [GW-1:0]                 wr_lo,
    input  logic [GW-1:0]                 wr_hi,
    input  rgn_attr_t                     wr_attr,
    output logic [NUM_RGN-1:0][GW-1:0]    lo_o,
    output logic [NUM_RGN-1:0][GW-1:0]    hi_o,
    output rgn_attr_t [NUM_RGN-1:0]       attr_o
);

    typedef struct packed {
        logic [NUM_RGN-1:0][GW-1:0] lo;
        logic [NUM_RGN-1:0][GW-1:0] hi;
        rgn_attr_t [NUM_RGN-1:0]    attr;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en && (int'(wr_sel) < NUM_RGN)) begin
            tbl_d.lo[wr_sel]   = wr_lo;
            tbl_d.hi[wr_sel]   = wr_hi;
            tbl_d.attr[wr_sel] = wr_attr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    assign lo_o   = tbl_q.lo;
    assign hi_o   = tbl_q.hi;
    assign attr_o = tbl_q.attr;

endmodule

// File: rtl/rgn_match.sv
module rgn_match
    import rgn_pkg::*;
#(
    parameter int NUM_RGN = 8,
    parameter int GW      = 21
) (
    input  logic [NUM_RGN-1:0][GW-1:0] lo_i,
    input  logic [NUM_RGN-1:0][GW-1:0] hi_i,
    input  rgn_attr_t [NUM_RGN-1:0]    attr_i,
    input  logic                       acc_valid,
    input  logic [GW-1:0]              acc_gran,
    input  acc_kind_e                  acc_kind,
    input  logic                       acc_super,
    output logic                       allow_o,
    output logic                       fault_o
);

    logic [NUM_RGN-1:0] hit_w;
    logic [NUM_RGN-1:0] perm_w;

    for (genvar i = 0; i < NUM_RGN; i++) begin : g_rgn
        always_comb begin
            hit_w[i] = attr_i[i].en && (acc_gran >= lo_i[i]) && (acc_gran <= hi_i[i]);
            unique case (acc_kind)
                KIND_LOAD:  perm_w[i] = hit_w[i];
                KIND_STORE: perm_w[i] = hit_w[i] && !attr_i[i].nw;
                KIND_FETCH: perm_w[i] = hit_w[i] && !attr_i[i].nx;
                default:    perm_w[i] = 1'b0;
            endcase
        end
    end

    always_comb begin
        allow_o = !acc_valid || acc_super || (|perm_w);
        fault_o = !allow_o;
    end

endmodule

// File: rtl/rgn_capture.sv
module rgn_capture
    import rgn_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fault_i,
    input  logic [AW-1:0] addr_i,
    input  acc_kind_e     kind_i,
    input  logic          clr_i,
    output logic          nmi_o,
    output logic          valid_o,
    output logic [AW-1:0] addr_o,
    output acc_kind_e     kind_o
);

    typedef struct packed {
        logic          nmi;
        logic          valid;
        logic [AW-1:0] addr;
        acc_kind_e     kind;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.nmi = fault_i;
        if (fault_i && (!cap_q.valid || clr_i)) begin
            cap_d.valid = 1'b1;
            cap_d.addr  = addr_i;
            cap_d.kind  = kind_i;
        end else if (clr_i) begin
            cap_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign nmi_o   = cap_q.nmi;
    assign valid_o = cap_q.valid;
    assign addr_o  = cap_q.addr;
    assign kind_o  = cap_q.kind;

    // R8
    hold_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !clr_i) |=> (valid_o && $stable(addr_o) && $stable(kind_o)));

    // R8
    first_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_i && !valid_o) |=> (valid_o && addr_o == $past(addr_i)));

    // R9
    clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !fault_i) |=> !valid_o);

endmodule

// File: rtl/rgn_guard.sv
module rgn_guard
    import rgn_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int NUM_RGN = 8,
    parameter int GRAN_LG = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [((NUM_RGN > 1) ? $clog2(NUM_RGN) : 1)-1:0] cfg_sel,
    input  logic [ADDR_W-GRAN_LG-1:0]         cfg_lo,
    input  logic [ADDR_W-GRAN_LG-1:0]         cfg_hi,
    input  logic                              cfg_en,
    input  logic                              cfg_nw,
    input  logic                              cfg_nx,
    input  logic                              acc_valid,
    input  logic [ADDR_W-1:0]                 acc_addr,
    input  logic [1:0]                        acc_kind,
    input  logic                              acc_super,
    input  logic                              sts_clr,
    output logic                              acc_allow,
    output logic                              nmi_req,
    output logic                              sts_valid,
    output logic [ADDR_W-1:0]                 sts_addr,
    output logic [1:0]                        sts_kind
);

    localparam int GW    = ADDR_W - GRAN_LG;
    localparam int IDX_W = (NUM_RGN > 1) ? $clog2(NUM_RGN) : 1;

    logic [NUM_RGN-1:0][GW-1:0] lo_w, hi_w;
    rgn_attr_t [NUM_RGN-1:0]    attr_w;
    rgn_attr_t                  wr_attr_w;
    acc_kind_e                  kind_w, rec_kind_w;
    logic                       fault_w;

    assign wr_attr_w = '{en: cfg_en, nw: cfg_nw, nx: cfg_nx};
    assign kind_w    = acc_kind_e'(acc_kind);

    rgn_table #(.NUM_RGN(NUM_RGN), .GW(GW), .IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_lo   (cfg_lo),
        .wr_hi   (cfg_hi),
        .wr_attr (wr_attr_w),
        .lo_o    (lo_w),
        .hi_o    (hi_w),
        .attr_o  (attr_w)
    );

    rgn_match #(.NUM_RGN(NUM_RGN), .GW(GW)) u_match (
        .lo_i      (lo_w),
        .hi_i      (hi_w),
        .attr_i    (attr_w),
        .acc_valid (acc_valid),
        .acc_gran  (acc_addr[ADDR_W-1:GRAN_LG]),
        .acc_kind  (kind_w),
        .acc_super (acc_super),
        .allow_o   (acc_allow),
        .fault_o   (fault_w)
    );

    rgn_capture #(.AW(ADDR_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .fault_i (fault_w),
        .addr_i  (acc_addr),
        .kind_i  (kind_w),
        .clr_i   (sts_clr),
        .nmi_o   (nmi_req),
        .valid_o (sts_valid),
        .addr_o  (sts_addr),
        .kind_o  (rec_kind_w)
    );

    assign sts_kind = rec_kind_w;

    // R5
    super_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_super) |-> acc_allow);

    // R6
    idle_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> acc_allow);

    // R7
    nmi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> $past(acc_valid && !acc_super && !acc_allow));

    // R7
    nmi_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_allow) |=> nmi_req);

endmodule

// File: tb/rgn_guard_tb.sv
`timescale 1ns/1ps
module rgn_guard_tb;

    localparam int AW = 24;
    localparam int GW = 21;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we, cfg_en, cfg_nw, cfg_nx;
    logic [2:0]    cfg_sel;
    logic [GW-1:0] cfg_lo, cfg_hi;
    logic          acc_valid, acc_super, sts_clr;
    logic [AW-1:0] acc_addr;
    logic [1:0]    acc_kind;
    logic          acc_allow, nmi_req, sts_valid;
    logic [AW-1:0] sts_addr;
    logic [1:0]    sts_kind;

    always #4 clk = ~clk;

    rgn_guard u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .cfg_en(cfg_en), .cfg_nw(cfg_nw), .cfg_nx(cfg_nx),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_kind(acc_kind),
        .acc_super(acc_super), .sts_clr(sts_clr),
        .acc_allow(acc_allow), .nmi_req(nmi_req), .sts_valid(sts_valid),
        .sts_addr(sts_addr), .sts_kind(sts_kind)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [GW-1:0] m_lo [8];
    logic [GW-1:0] m_hi [8];
    logic          m_en [8];
    logic          m_nw [8];
    logic          m_nx [8];
    logic          m_sv;
    logic [AW-1:0] m_sa;
    logic [1:0]    m_sk;
    logic          exp_q [$];

    task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic model_allow(logic [AW-1:0] a, logic [1:0] k, logic s);
        logic ok = 1'b0;
        if (s) return 1'b1;
        if (k == 2'd3) return 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (m_en[i] && a[AW-1:3] >= m_lo[i] && a[AW-1:3] <= m_hi[i]) begin
                if (k == 2'd0) ok = 1'b1;
                if (k == 2'd1 && !m_nw[i]) ok = 1'b1;
                if (k == 2'd2 && !m_nx[i]) ok = 1'b1;
            end
        end
        return ok;
    endfunction

    task automatic quiet();
        cfg_we = 0; acc_valid = 0; sts_clr = 0; acc_super = 0;
    endtask

    task automatic idle();
        @(negedge clk);
        quiet();
        exp_q.push_back(1'b0);
    endtask

    // R1: descriptor write
    task automatic set_rgn(int idx, int lo, int hi, logic en, logic nw, logic nx);
        @(negedge clk);
        quiet();
        cfg_we = 1; cfg_sel = 3'(idx); cfg_lo = GW'(lo); cfg_hi = GW'(hi);
        cfg_en = en; cfg_nw = nw; cfg_nx = nx;
        m_lo[idx] = GW'(lo); m_hi[idx] = GW'(hi);
        m_en[idx] = en; m_nw[idx] = nw; m_nx[idx] = nx;
        exp_q.push_back(1'b0);
    endtask

    task automatic access(string req, int addr, logic [1:0] k, logic s, logic clr);
        logic exp;
        @(negedge clk);
        quiet();
        acc_valid = 1; acc_addr = AW'(addr); acc_kind = k; acc_super = s; sts_clr = clr;
        #1;
        exp = model_allow(AW'(addr), k, s);
        cmp(req, {31'd0, acc_allow}, {31'd0, exp});
        exp_q.push_back(!exp);
        if (!exp && (!m_sv || clr)) begin
            m_sv = 1; m_sa = AW'(addr); m_sk = k;
        end else if (clr) begin
            m_sv = 0;
        end
    endtask

    task automatic clear();
        @(negedge clk);
        quiet();
        sts_clr = 1;
        m_sv = 0;
        exp_q.push_back(1'b0);
    endtask

    task automatic check_sts(string req);
        idle();
        cmp({req, " valid"}, {31'd0, sts_valid}, {31'd0, m_sv});
        if (m_sv) begin
            cmp({req, " addr"}, {8'd0, sts_addr}, {8'd0, m_sa});
            cmp({req, " kind"}, {30'd0, sts_kind}, {30'd0, m_sk});
        end
    endtask

    // R7 scoreboard monitor: one expectation per driven cycle
    always @(posedge clk) begin
        if (rst_n === 1'b1) begin
            logic e;
            #2;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b0;
            cmp("R7 nmi", {31'd0, nmi_req}, {31'd0, e});
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_lo[i] = '0; m_hi[i] = '0; m_en[i] = 0; m_nw[i] = 0; m_nx[i] = 0;
        end
        m_sv = 0; m_sa = '0; m_sk = '0;
        rst_n = 0; quiet();
        cfg_sel = '0; cfg_lo = '0; cfg_hi = '0; cfg_en = 0; cfg_nw = 0; cfg_nx = 0;
        acc_addr = '0; acc_kind = '0;
        repeat (3) @(negedge clk);
        cmp("R1 reset sts_valid", {31'd0, sts_valid}, 32'd0);
        cmp("R1 reset nmi", {31'd0, nmi_req}, 32'd0);
        rst_n = 1;
        // R6: empty table denies user, idle allows
        idle();
        cmp("R6 idle allow", {31'd0, acc_allow}, 32'd1);
        access("R6 empty table", 'h100, 2'd0, 0, 0);
        access("R5 super empty", 'h100, 2'd2, 1, 0);
        check_sts("R8 first record");
        access("R8 second fault", 'h208, 2'd1, 0, 0);
        check_sts("R8 record kept");
        clear();
        check_sts("R9 cleared");
        // R1 table setup
        set_rgn(0, 'h200, 'h3FF, 1, 0, 1);
        set_rgn(1, 'h400, 'h400, 1, 1, 0);
        set_rgn(2, 'h300, 'h31F, 1, 0, 0);
        set_rgn(3, 'h800, 'h801, 1, 0, 0);
        set_rgn(7, 'h600, 'h6FF, 0, 0, 0);
        // R3 kinds
        access("R3 load", 'h1000, 2'd0, 0, 0);
        access("R3 store ok", 'h1FF8, 2'd1, 0, 0);
        access("R3 fetch no-exec", 'h1004, 2'd2, 0, 0);
        access("R3 store no-write", 'h2000, 2'd1, 0, 0);
        access("R3 fetch ok", 'h2004, 2'd2, 0, 0);
        // R4 overlap
        access("R4 overlap fetch", 'h1810, 2'd2, 0, 0);
        access("R4 overlap edge", 'h1900, 2'd2, 0, 0);
        // R2 granularity
        access("R2 low edge", 'h4000, 2'd0, 0, 0);
        access("R2 high edge", 'h400F, 2'd1, 0, 0);
        access("R2 past end", 'h4010, 2'd0, 0, 0);
        access("R2 below start", 'h3FFF, 2'd0, 0, 0);
        access("R2 end granule", 'h2007, 2'd0, 0, 0);
        access("R2 next granule", 'h2008, 2'd0, 0, 0);
        // R6 disabled entry, reserved kind
        access("R6 disabled entry", 'h3010, 2'd0, 0, 0);
        access("R6 reserved kind", 'h1000, 2'd3, 0, 0);
        access("R5 super fetch", 'h1004, 2'd2, 1, 0);
        check_sts("R8 record after burst");
        // R9 clear with simultaneous fault
        access("R9 clear+fault", 'h5550, 2'd2, 0, 1);
        check_sts("R9 clear+fault record");
        access("R9 clear+allowed", 'h1000, 2'd0, 0, 1);
        check_sts("R9 clear alone");
        // R1 rewrite takes effect
        set_rgn(0, 'h200, 'h3FF, 1, 0, 0);
        access("R1 rewritten entry", 'h1004, 2'd2, 0, 0);
        set_rgn(0, 'h200, 'h3FF, 0, 0, 0);
        access("R1 disabled entry", 'h1000, 2'd0, 0, 0);
        check_sts("R8 record final");
        idle(); idle();
        done = 1'b1;
        summary();
    end

endmodule